// File: doc/BRIEF.md
# NVRAM Header Checksum Sequencer

This block walks a byte-addressed nonvolatile memory region and computes a 16-bit checksum over it. It reads one byte per request/acknowledge transaction, forms big-endian 16-bit words from adjacent bytes, and folds each word into a running value with a nibble-based update. Word fetches advance by one byte, so each word shares a byte with the word before it. Each byte is therefore read only once: the low byte of one word is kept and becomes the high byte of the next.

A start strobe captures the start address, the byte count, a write-back enable and a write-back address. When the pass ends, and write-back is enabled, the sequencer stores the checksum into memory at the write-back address. The high byte goes first and the low byte goes at the next address. The sequencer then raises a one-cycle done pulse, and the result stays on its output until the next pass completes. For a configuration header, the typical use is a count of 0xF8 from address 0 with write-back to 0xFC.

Top module: `nvck_seq`

## Requirements
- R1: After reset, crc_out is 0xFFFF, done is 0 and mem_req is 0.
- R2: The running value starts at 0xFFFF. One fold of word w into value v gives: t = v>>8, p = v^w, a = p[3:0], b = p[7:4]^a, result = t ^ (a<<3) ^ (a<<8) ^ b ^ (b<<7) ^ (b<<12), all 16 bits. Folding word 0x0000 into 0xFFFF gives 0x0F87.
- R3: Let N be the byte count rounded down to even. Exactly N folds run, and fold i uses the word {byte[start+i], byte[start+i+1]}, with the first byte in bits 15:8.
- R4: For an odd count, one extra fold runs on {byte[start+N], 8'h00}. A count of 1 therefore yields the fold of {byte[start], 8'h00}.
- R5: A count of 0 performs no read and finishes with a result of 0xFFFF. The write-back still takes place when it is enabled.
- R6: A transaction is held until mem_ack: mem_req, mem_addr and mem_we stay stable while mem_req is high and mem_ack is low. The read data is taken in the cycle where mem_ack is high, so any latency works.
- R7: Each byte is read once, in ascending address order. The addresses run from start to start+N when N > 0, and cover start alone when the count is 1. Addresses wrap modulo 2^AW.
- R8: When write-back is enabled, two writes with mem_we=1 follow the reads. The first writes crc[15:8] to the write-back address, and the second writes crc[7:0] to that address plus 1. When write-back is disabled, no write occurs.
- R9: done is high for exactly one cycle per pass. crc_out changes only in the cycle where done is high, and then holds until the next pass ends.
- R10: A start strobe received while a pass is in progress is ignored. The pass in progress finishes with its original parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start strobe, sampled only when idle |
| base_addr | input | AW | First byte address of the region |
| byte_cnt | input | CW | Number of bytes covered |
| wb_en | input | 1 | Store the result into memory after the pass |
| wb_addr | input | AW | Address of the high result byte |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the transaction |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Transaction completion, one cycle |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| crc_out | output | 16 | Last completed checksum |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that memory raises mem_ack only while mem_req is high, that mem_ack lasts a single cycle, and that a free cycle follows each acknowledge. The step counter also assumes that the sequencer never asks it to count below zero. The bench memory model follows these rules: it acknowledges only a pending request, drops mem_ack on the following cycle, and draws a random latency of zero to a few cycles for each transaction. Start strobes are driven only at idle, except for the deliberate busy-time strobe used for R10.

// File: rtl/nvck_pkg.sv
package nvck_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_RD0   = 3'd1,
    S_RDN   = 3'd2,
    S_TAIL  = 3'd3,
    S_WRH   = 3'd4,
    S_WRL   = 3'd5,
    S_FIN   = 3'd6
  } nvck_st_e;

  localparam logic [15:0] NVCK_SEED = 16'hFFFF;
endpackage

// File: rtl/nvck_fold.sv
module nvck_fold (
  input  logic [15:0] prev,
  input  logic [15:0] word,
  output logic [15:0] nxt
);
  logic [15:0] mix;
  logic [3:0]  lo_n;
  logic [3:0]  hi_n;

  always_comb begin
    mix  = prev ^ word;
    lo_n = mix[3:0];
    hi_n = mix[7:4] ^ lo_n;
    nxt  = {8'h00, prev[15:8]}
         ^ {9'b0, lo_n, 3'b0}
         ^ {4'b0, lo_n, 8'b0}
         ^ {12'b0, hi_n}
         ^ {5'b0, hi_n, 7'b0}
         ^ {hi_n, 12'b0};
  end
endmodule

// File: rtl/nvck_ctr.sv
module nvck_ctr #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] ld_val,
  output logic         is_zero,
  output logic         is_one
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = load ? ld_val : (cnt_q - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign is_zero = (cnt_q == '0);
  assign is_one  = (cnt_q == ONE);

  // R3: no more folds than the rounded count
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> (cnt_q != '0));
endmodule

// File: rtl/nvck_seq.sv
module nvck_seq
  import nvck_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] byte_cnt,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_ack,
  input  logic [7:0]    mem_rdata,
  output logic [15:0]   crc_out,
  output logic          done
);
  localparam logic [AW-1:0] ADDR_ONE = AW'(1);

  nvck_st_e      st_q, st_d, st_after;
  logic [AW-1:0] addr_q, addr_d, wba_q;
  logic [15:0]   crc_q, crc_d, res_q, fold_word, fold_out;
  logic [7:0]    hi_q;
  logic          odd_q, wbe_q;
  logic          hi_en, res_en, cap_en;
  logic          ctr_load, ctr_dec, ctr_zero, ctr_one;
  logic [CW-1:0] even_cnt;

  assign even_cnt = {byte_cnt[CW-1:1], 1'b0};

  nvck_fold u_fold (.prev(crc_q), .word(fold_word), .nxt(fold_out));

  nvck_ctr #(.W(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .dec(ctr_dec),
    .ld_val(even_cnt), .is_zero(ctr_zero), .is_one(ctr_one)
  );

  always_comb begin
    case (st_q)
      S_RD0:   fold_word = {mem_rdata, 8'h00};
      S_TAIL:  fold_word = {hi_q, 8'h00};
      default: fold_word = {hi_q, mem_rdata};
    endcase
  end

  always_comb begin
    st_after = wbe_q ? S_WRH : S_FIN;
    st_d     = st_q;
    addr_d   = addr_q;
    crc_d    = crc_q;
    hi_en    = 1'b0;
    cap_en   = 1'b0;
    ctr_load = 1'b0;
    ctr_dec  = 1'b0;
    case (st_q)
      S_IDLE: if (go) begin
        cap_en   = 1'b1;
        ctr_load = 1'b1;
        crc_d    = NVCK_SEED;
        if (byte_cnt == '0) begin
          st_d   = wb_en ? S_WRH : S_FIN;
          addr_d = wb_addr;
        end else begin
          st_d   = S_RD0;
          addr_d = base_addr;
        end
      end
      S_RD0: if (mem_ack) begin
        hi_en  = 1'b1;
        addr_d = addr_q + ADDR_ONE;
        if (ctr_zero) begin
          crc_d = fold_out;
          st_d  = st_after;
          if (wbe_q) addr_d = wba_q;
        end else begin
          st_d = S_RDN;
        end
      end
      S_RDN: if (mem_ack) begin
        hi_en   = 1'b1;
        ctr_dec = 1'b1;
        crc_d   = fold_out;
        addr_d  = addr_q + ADDR_ONE;
        if (ctr_one) begin
          if (odd_q) st_d = S_TAIL;
          else begin
            st_d = st_after;
            if (wbe_q) addr_d = wba_q;
          end
        end
      end
      S_TAIL: begin
        crc_d = fold_out;
        st_d  = st_after;
        if (wbe_q) addr_d = wba_q;
      end
      S_WRH: if (mem_ack) begin
        addr_d = addr_q + ADDR_ONE;
        st_d   = S_WRL;
      end
      S_WRL: if (mem_ack) st_d = S_FIN;
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
    res_en = (st_d == S_FIN) && (st_q != S_FIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      crc_q  <= NVCK_SEED;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      crc_q  <= crc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      res_q <= NVCK_SEED;
      odd_q <= 1'b0;
      wbe_q <= 1'b0;
      wba_q <= '0;
    end else begin
      if (hi_en)  hi_q  <= mem_rdata;
      if (res_en) res_q <= crc_d;
      if (cap_en) begin
        odd_q <= byte_cnt[0];
        wbe_q <= wb_en;
        wba_q <= wb_addr;
      end
    end
  end

  assign mem_req   = (st_q == S_RD0) || (st_q == S_RDN) || (st_q == S_WRH) || (st_q == S_WRL);
  assign mem_we    = (st_q == S_WRH) || (st_q == S_WRL);
  assign mem_addr  = addr_q;
  assign mem_wdata = (st_q == S_WRH) ? crc_q[15:8] : crc_q[7:0];
  assign crc_out   = res_q;
  assign done      = (st_q == S_FIN);

  // R6: a pending transaction keeps its request, address and direction
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: result only moves together with done
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(crc_out));

  // R8: write data follows the high-then-low order of the held checksum
  p_wr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata));
endmodule

// File: tb/sim_nvck_seq.sv
module sim_nvck_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int CW = 9;

  logic clk, rst_n, go, wb_en, mem_ack, mem_req, mem_we, done;
  logic [AW-1:0] base_addr, wb_addr, mem_addr;
  logic [CW-1:0] byte_cnt;
  logic [7:0] mem_wdata, mem_rdata;
  logic [15:0] crc_out;

  nvck_seq #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .base_addr(base_addr), .byte_cnt(byte_cnt),
    .wb_en(wb_en), .wb_addr(wb_addr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .crc_out(crc_out), .done(done)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [0:255];
  logic [7:0] rd_log [0:511];
  logic [7:0] wr_a [0:3];
  logic [7:0] wr_d [0:3];
  int rd_n, wr_n, lat, lat_max;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (lat <= 0) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          if (wr_n < 4) begin wr_a[wr_n] = mem_addr; wr_d[wr_n] = mem_wdata; end
          wr_n++;
        end else begin
          mem_rdata = mem[mem_addr];
          if (rd_n < 512) rd_log[rd_n] = mem_addr;
          rd_n++;
        end
        lat = (lat_max == 0) ? 0 : int'($urandom % (lat_max + 1));
      end else lat--;
    end
  end

  function automatic logic [15:0] f_step(logic [15:0] pv, logic [15:0] w);
    logic [15:0] t, p, a, b;
    t = pv >> 8;
    p = pv ^ w;
    a = p & 16'h000F;
    b = ((p >> 4) & 16'h000F) ^ a;
    return t ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12);
  endfunction

  function automatic logic [15:0] f_ref(logic [7:0] st, logic [8:0] cn);
    logic [15:0] c;
    int n;
    c = 16'hFFFF;
    n = int'(cn) & ~1;
    for (int i = 0; i < n; i++)
      c = f_step(c, {mem[8'(int'(st) + i)], mem[8'(int'(st) + i + 1)]});
    if (cn[0]) c = f_step(c, {mem[8'(int'(st) + n)], 8'h00});
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] st, input logic [8:0] cn, input logic wb,
                     input logic [7:0] wa, input bit poke);
    logic [15:0] exp;
    int nrd, k;
    exp = f_ref(st, cn);
    nrd = (cn == 0) ? 0 : (cn[0] ? int'(cn) : int'(cn) + 1);
    rd_n = 0; wr_n = 0;
    @(negedge clk);
    go = 1'b1; base_addr = st; byte_cnt = cn; wb_en = wb; wb_addr = wa;
    @(negedge clk);
    go = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      go = 1'b1; base_addr = st + 8'd7; byte_cnt = 9'd0; wb_en = 1'b1; wb_addr = 8'hF0;
      @(negedge clk);
      go = 1'b0;
    end
    k = 0;
    while (!done && k < 20000) begin @(negedge clk); k++; end
    chk("R9 done seen", {31'b0, done}, 32'd1);
    if (poke) chk("R10 busy start ignored", {16'b0, crc_out}, {16'b0, exp});
    else      chk("R3/R4 checksum", {16'b0, crc_out}, {16'b0, exp});
    chk("R7 read count", rd_n, nrd);
    for (int i = 0; i < nrd && i < 512; i++)
      if (rd_log[i] !== 8'(int'(st) + i)) chk("R7 read order", {24'b0, rd_log[i]}, 8'(int'(st) + i));
    if (wb) begin
      chk("R8 write count", wr_n, 2);
      chk("R8 high addr", {24'b0, wr_a[0]}, {24'b0, wa});
      chk("R8 high data", {24'b0, wr_d[0]}, {24'b0, exp[15:8]});
      chk("R8 low addr", {24'b0, wr_a[1]}, {24'b0, wa + 8'd1});
      chk("R8 low data", {24'b0, wr_d[1]}, {24'b0, exp[7:0]});
    end else chk("R8 no write", wr_n, 0);
    @(negedge clk);
    chk("R9 pulse ends", {31'b0, done}, 32'd0);
    chk("R9 result held", {16'b0, crc_out}, {16'b0, exp});
  endtask

  initial begin
    rst_n = 1'b0; go = 1'b0; base_addr = '0; byte_cnt = '0; wb_en = 1'b0; wb_addr = '0;
    mem_ack = 1'b0; mem_rdata = '0; rd_n = 0; wr_n = 0; lat = 0; lat_max = 2;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 crc_out reset", {16'b0, crc_out}, 32'hFFFF);
    chk("R1 done reset", {31'b0, done}, 0);
    chk("R1 req reset", {31'b0, mem_req}, 0);
    // R2/R4: single zero byte folds as word 0x0000 into the seed
    mem[8'h40] = 8'h00;
    run(8'h40, 9'd1, 1'b0, 8'h00, 1'b0);
    chk("R2 literal fold", {16'b0, crc_out}, 32'h0F87);
    // R5: empty region, with and without write-back
    run(8'h10, 9'd0, 1'b1, 8'h80, 1'b0);
    chk("R5 empty result", {16'b0, crc_out}, 32'hFFFF);
    run(8'h10, 9'd0, 1'b0, 8'h80, 1'b0);
    // R3: header pass with write-back into the header
    run(8'h00, 9'h0F8, 1'b1, 8'hFC, 1'b0);
    // R6: zero latency then long latency
    lat_max = 0;
    run(8'h20, 9'd6, 1'b1, 8'hA0, 1'b0);
    lat_max = 5;
    run(8'h30, 9'd7, 1'b0, 8'h00, 1'b0);
    // R7: wrap at the top of the address space, R4 odd count
    lat_max = 2;
    run(8'hFB, 9'd9, 1'b0, 8'h00, 1'b0);
    run(8'h55, 9'd2, 1'b1, 8'hC0, 1'b0);
    // R10: start strobe while busy
    run(8'h60, 9'd20, 1'b0, 8'h00, 1'b1);
    for (int r = 0; r < 20; r++)
      run(8'($urandom), 9'($urandom % 41), 1'($urandom), 8'(8'hC8 + ($urandom % 32)), 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule